// File: doc/BRIEF.md
# Serial Transmitter with Start-up Preamble

This block turns bytes written by a bus master into an asynchronous serial stream on one output pin. A write lands in a one-entry holding register. When the shift stage is free, the byte moves into it and goes out as a start bit of 0, the data bits least significant first, and a stop bit of 1. A mode input picks 8 or 9 data bits per character. Bit timing comes from an external oversampling tick, and each bit lasts 16 ticks.

Two sticky status flags report progress. The data-empty flag says that the holding register may take a new byte. The complete flag says that nothing is queued or on the wire and the line is idle. Each flag drops only when software writes a 1 to its clear strobe. Whenever the block leaves its disabled state, it first sends one idle character of all 1s, so the receiver sees a clean line before any data. The end of that character can be seen on the complete flag. A break request sends a character of all 0s, then a stop bit.

Top module: `uart_pretx`

## Requirements
- R1: After reset, `txd` is 1, `tde_flag` is 1 and `tc_flag` is 1.
- R2: With `mode9`=0, a data character is one start bit (0), then `wr_data[7:0]` least significant bit first, then one stop bit (1). Each bit lasts 16 `baud_tick` pulses.
- R3: With `mode9`=1, a data character carries nine data bits, `wr_data[8:0]`, least significant bit first, between the start bit and the stop bit.
- R4: When `mod_off` goes from 1 to 0, the block sends an idle character of 1s, 10 bit times long (`mode9`=0) or 11 bit times long (`mode9`=1), before anything else. `tc_flag` is 0 while it is pending or sent, and it rises after it ends.
- R5: `tde_flag` rises when the shift stage takes a byte from the holding register.
- R6: `tc_flag` is 0 while a character of any kind is queued or being shifted. It rises when a character ends with `tde_flag` set and nothing queued.
- R7: `tde_flag` and `tc_flag` hold their value until a 1 is pulsed on `clr_tde` or `clr_tc`. Each strobe clears only its own flag.
- R8: A pulse on `brk_req` sends 10 (`mode9`=0) or 11 (`mode9`=1) bit times of 0, followed by a stop bit of 1.
- R9: A byte written while the holding register is still full replaces the queued byte. The character already in the shift stage goes out unchanged.
- R10: While `tc_flag` is 1, `txd` is 1.
- R11: While `mod_off` is 1, no character starts, any character in progress is abandoned, `txd` is 1 from the next cycle on, and `brk_req` is ignored.
- R12: Bit timing advances only on `baud_tick`. With no tick, `txd` holds its level in the middle of a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| baud_tick | input | 1 | Oversampling tick, 16 per bit time |
| mode9 | input | 1 | 1 selects nine data bits, 0 selects eight |
| mod_off | input | 1 | Module disable. A falling edge arms the idle preamble |
| brk_req | input | 1 | One-cycle request to send a break character |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Byte to send (bit 8 is used only in nine-bit mode) |
| clr_tde | input | 1 | Write-1 strobe that clears `tde_flag` |
| clr_tc | input | 1 | Write-1 strobe that clears `tc_flag` |
| txd | output | 1 | Serial output, idle high |
| tde_flag | output | 1 | Holding register empty flag |
| tc_flag | output | 1 | Transmission complete flag |

## Verification
The assertions assume three things about the inputs: `mod_off` is steady within a cycle, `baud_tick` is a single-cycle pulse, and `mode9` does not change between a write and the start of that character. The bench drives every input on the falling clock edge. It changes `mode9` only while the line is idle, and it holds `baud_tick` high except during the window that tests tick gating. Every timing check is placed in the middle of a bit or at least half a bit away from an expected flag edge. This keeps the checks clear of the one or two cycles of load latency.

// File: rtl/tx_pkg.sv
package tx_pkg;

  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_PRE  = 2'd1,
    LD_BRK  = 2'd2,
    LD_DAT  = 2'd3
  } ld_kind_t;

  function automatic int unsigned char_bits(input logic m9, input int unsigned dw);
    return (m9 ? dw : dw - 1) + 2;
  endfunction

endpackage

// File: rtl/tx_holdreg.sv
module tx_holdreg #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data
);

  logic          full_q, full_n;
  logic [DW-1:0] data_q, data_n;

  always_comb begin
    full_n = full_q;
    data_n = data_q;
    if (take) full_n = 1'b0;
    if (wr) begin
      full_n = 1'b1;
      data_n = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_n;
      if (wr) data_q <= data_n;
    end
  end

  assign full = full_q;
  assign data = data_q;

endmodule

// File: rtl/tx_bitshift.sv
module tx_bitshift #(
  parameter int FW  = 12,
  parameter int OVS = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       kill,
  input  logic                       tick,
  input  logic                       load,
  input  logic [FW-1:0]              ld_bits,
  input  logic [$clog2(FW+1)-1:0]    ld_len,
  output logic                       busy,
  output logic                       fin,
  output logic                       txd
);

  localparam int LW = $clog2(FW + 1);
  localparam int TW = $clog2(OVS);
  localparam logic [TW-1:0] TLAST = TW'(OVS - 1);

  logic          busy_q, busy_n;
  logic [FW-1:0] sh_q, sh_n;
  logic [LW-1:0] left_q, left_n;
  logic [TW-1:0] tcnt_q, tcnt_n;
  logic          tcnt_en;

  always_comb begin
    busy_n  = busy_q;
    sh_n    = sh_q;
    left_n  = left_q;
    tcnt_n  = tcnt_q;
    tcnt_en = 1'b0;
    fin     = 1'b0;
    if (kill) begin
      busy_n = 1'b0;
      fin    = busy_q;
    end else if (load && !busy_q) begin
      busy_n  = 1'b1;
      sh_n    = ld_bits;
      left_n  = ld_len;
      tcnt_n  = '0;
      tcnt_en = 1'b1;
    end else if (busy_q && tick) begin
      tcnt_en = 1'b1;
      if (tcnt_q == TLAST) begin
        tcnt_n = '0;
        sh_n   = {1'b1, sh_q[FW-1:1]};
        left_n = left_q - LW'(1);
        if (left_q == LW'(1)) begin
          busy_n = 1'b0;
          fin    = 1'b1;
        end
      end else begin
        tcnt_n = tcnt_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      tcnt_q <= '0;
    end else begin
      busy_q <= busy_n;
      sh_q   <= sh_n;
      left_q <= left_n;
      if (tcnt_en) tcnt_q <= tcnt_n;
    end
  end

  assign busy = busy_q;
  assign txd  = busy_q ? sh_q[0] : 1'b1;

endmodule

// File: rtl/tx_statflags.sv
module tx_statflags (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic load_any,
  input  logic load_dat,
  input  logic fin,
  input  logic pend_any,
  input  logic clr_tde,
  input  logic clr_tc,
  output logic tde,
  output logic tc
);

  logic tde_q, tde_n;
  logic tc_q, tc_n;

  always_comb begin
    tde_n = tde_q;
    if (clr_tde)  tde_n = 1'b0;
    if (load_dat) tde_n = 1'b1;

    tc_n = tc_q;
    if (clr_tc) tc_n = 1'b0;
    if (fin && tde_n && !pend_any) tc_n = 1'b1;
    if (load_any || arm) tc_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tde_q <= 1'b1;
      tc_q  <= 1'b1;
    end else begin
      tde_q <= tde_n;
      tc_q  <= tc_n;
    end
  end

  assign tde = tde_q;
  assign tc  = tc_q;

endmodule

// File: rtl/uart_pretx.sv
module uart_pretx #(
  parameter int DW  = 9,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          mode9,
  input  logic          mod_off,
  input  logic          brk_req,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          clr_tde,
  input  logic          clr_tc,
  output logic          txd,
  output logic          tde_flag,
  output logic          tc_flag
);

  import tx_pkg::*;

  localparam int FW = DW + 3;
  localparam int LW = $clog2(FW + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  // sequencing state
  logic     off_q;
  logic     pre_q, pre_n;
  logic     brk_q, brk_n;
  logic     en_rise, brk_acc, arm;
  logic     busy, fin, full, can_load;
  logic     ld_pre, ld_brk, ld_dat, ld_any;
  ld_kind_t ld_kind;
  logic [DW-1:0] hold_data;
  logic [FW-1:0] ld_bits, dext;
  logic [LW-1:0] ld_len, n_char;

  assign en_rise  = off_q && !mod_off;
  assign brk_acc  = brk_req && !mod_off;
  assign arm      = en_rise || brk_acc || wr_en;
  assign can_load = !busy && !mod_off;

  always_comb begin
    ld_kind = LD_NONE;
    if (can_load) begin
      if (pre_q)      ld_kind = LD_PRE;
      else if (brk_q) ld_kind = LD_BRK;
      else if (full)  ld_kind = LD_DAT;
    end
  end

  assign ld_pre = (ld_kind == LD_PRE);
  assign ld_brk = (ld_kind == LD_BRK);
  assign ld_dat = (ld_kind == LD_DAT);
  assign ld_any = (ld_kind != LD_NONE);

  always_comb begin
    pre_n = pre_q;
    brk_n = brk_q;
    if (ld_pre)  pre_n = 1'b0;
    if (ld_brk)  brk_n = 1'b0;
    if (en_rise) pre_n = 1'b1;
    if (brk_acc) brk_n = 1'b1;
    if (mod_off) begin
      pre_n = 1'b0;
      brk_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      off_q <= 1'b1;
      pre_q <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      off_q <= mod_off;
      pre_q <= pre_n;
      brk_q <= brk_n;
    end
  end

  // character image for the shift stage
  assign n_char = LW'(char_bits(mode9, DW));
  assign dext   = {{(FW - DW){1'b0}}, hold_data};

  always_comb begin
    ld_bits = '1;
    for (int i = 0; i < FW; i++) begin
      if (ld_brk) begin
        ld_bits[i] = (i >= int'(n_char));
      end else if (ld_dat) begin
        if (i == 0)                    ld_bits[i] = 1'b0;
        else if (i < int'(n_char) - 1) ld_bits[i] = dext[i-1];
      end
    end
    ld_len = ld_brk ? n_char + LW'(1) : n_char;
  end

  tx_holdreg #(.DW(DW)) u_hold (
    .clk   (clk),
    .rst_n (rst_q),
    .wr    (wr_en),
    .wdata (wr_data),
    .take  (ld_dat),
    .full  (full),
    .data  (hold_data)
  );

  tx_bitshift #(.FW(FW), .OVS(OVS)) u_shift (
    .clk     (clk),
    .rst_n   (rst_q),
    .kill    (mod_off),
    .tick    (baud_tick),
    .load    (ld_any),
    .ld_bits (ld_bits),
    .ld_len  (ld_len),
    .busy    (busy),
    .fin     (fin),
    .txd     (txd)
  );

  tx_statflags u_flags (
    .clk      (clk),
    .rst_n    (rst_q),
    .arm      (arm),
    .load_any (ld_any),
    .load_dat (ld_dat),
    .fin      (fin),
    .pend_any (pre_q || brk_q || full),
    .clr_tde  (clr_tde),
    .clr_tc   (clr_tc),
    .tde      (tde_flag),
    .tc       (tc_flag)
  );

endmodule

// File: rtl/uart_pretx_chk.sv
module uart_pretx_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic mod_off,
  input logic clr_tde,
  input logic txd,
  input logic tde_flag,
  input logic tc_flag,
  input logic busy,
  input logic ld_dat
);

  // R5: taking a byte into the shift stage raises data-empty
  a_r5_tde_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    ld_dat |=> tde_flag);

  // R7: data-empty only falls after a clear strobe
  a_r7_tde_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tde_flag) |-> $past(clr_tde));

  // R6: complete is low while the shift stage is busy
  a_r6_tc_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tc_flag);

  // R10: line idles high while complete is set
  a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    tc_flag |-> txd);

  // R11: disabled means a high line from the next cycle
  a_r11_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mod_off |=> txd);

  // R12: no tick, no movement mid-character
  a_r12_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick && !mod_off) |=> $stable(txd));

endmodule

bind uart_pretx uart_pretx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .baud_tick (baud_tick),
  .mod_off   (mod_off),
  .clr_tde   (clr_tde),
  .txd       (txd),
  .tde_flag  (tde_flag),
  .tc_flag   (tc_flag),
  .busy      (busy),
  .ld_dat    (ld_dat)
);

// File: tb/tb_uart_pretx.sv
module tb_uart_pretx;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick, mode9, mod_off, brk_req, wr_en, clr_tde, clr_tc;
  logic [8:0] wr_data;
  logic       txd, tde_flag, tc_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  uart_pretx dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .mode9(mode9),
    .mod_off(mod_off), .brk_req(brk_req), .wr_en(wr_en), .wr_data(wr_data),
    .clr_tde(clr_tde), .clr_tc(clr_tc), .txd(txd), .tde_flag(tde_flag),
    .tc_flag(tc_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_byte(input logic [8:0] d);
    wr_data = d; wr_en = 1'b1;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic pulse_clr(input bit which_tc);
    if (which_tc) clr_tc = 1'b1; else clr_tde = 1'b1;
    cyc(1);
    clr_tc = 1'b0; clr_tde = 1'b0;
  endtask

  task automatic wait_tc(output bit ok);
    int t = 0;
    while (tc_flag !== 1'b1 && t < 600) begin cyc(1); t++; end
    ok = (tc_flag === 1'b1);
  endtask

  task automatic recv(input int nb, output logic [8:0] d, output logic stp, output bit got);
    int t = 0;
    d = '0; stp = 1'bx; got = 1'b0;
    while (txd !== 1'b0 && t < 600) begin cyc(1); t++; end
    if (txd !== 1'b0) return;
    got = 1'b1;
    cyc(8);
    for (int k = 0; k < nb; k++) begin cyc(16); d[k] = txd; end
    cyc(16);
    stp = txd;
  endtask

  task automatic t_reset;
    chk(txd === 1'b1, "R1 txd after reset", int'(txd), 1);
    chk(tde_flag === 1'b1, "R1 tde after reset", int'(tde_flag), 1);
    chk(tc_flag === 1'b1, "R1 tc after reset", int'(tc_flag), 1);
  endtask

  task automatic t_preamble(input logic m);
    int lows = 0;
    int t_lo = m ? 165 : 150;
    int t_hi = m ? 190 : 175;
    mode9 = m;
    mod_off = 1'b1; cyc(3);
    mod_off = 1'b0;
    for (int k = 1; k <= t_hi; k++) begin
      cyc(1);
      if (txd !== 1'b1) lows++;
      if (k == 3) chk(tc_flag === 1'b0, "R4 R6 tc low after enable", int'(tc_flag), 0);
      if (k == t_lo) chk(tc_flag === 1'b0, "R4 tc low during preamble", int'(tc_flag), 0);
      if (k == t_hi) chk(tc_flag === 1'b1, "R4 tc high after preamble", int'(tc_flag), 1);
    end
    chk(lows == 0, "R4 preamble line all ones", lows, 0);
    mode9 = 1'b0;
  endtask

  task automatic t_frame8;
    logic [8:0] d; logic s; bit g; bit ok;
    pulse_clr(1'b0);
    chk(tde_flag === 1'b0, "R7 tde cleared by strobe", int'(tde_flag), 0);
    write_byte(9'h0A5);
    cyc(3);
    chk(tde_flag === 1'b1, "R5 tde set on take", int'(tde_flag), 1);
    chk(tc_flag === 1'b0, "R6 tc low while sending", int'(tc_flag), 0);
    recv(8, d, s, g);
    chk(g && d[7:0] == 8'hA5, "R2 eight-bit data", int'(d), 'hA5);
    chk(s === 1'b1, "R2 stop bit", int'(s), 1);
    wait_tc(ok);
    chk(ok, "R6 tc rises after frame", int'(tc_flag), 1);
  endtask

  task automatic t_frame9;
    logic [8:0] d; logic s; bit g; bit ok;
    mode9 = 1'b1;
    write_byte(9'h13C);
    recv(9, d, s, g);
    chk(g && d == 9'h13C, "R3 nine-bit data", int'(d), 'h13C);
    chk(s === 1'b1, "R3 stop bit after nine bits", int'(s), 1);
    wait_tc(ok);
    mode9 = 1'b0;
  endtask

  task automatic t_break;
    int t = 0; int bad = 0; bit ok;
    brk_req = 1'b1; cyc(1); brk_req = 1'b0;
    while (txd !== 1'b0 && t < 100) begin cyc(1); t++; end
    cyc(8);
    for (int k = 0; k < 10; k++) begin
      if (txd !== 1'b0) bad++;
      cyc(16);
    end
    chk(bad == 0, "R8 break holds low ten bits", bad, 0);
    chk(txd === 1'b1, "R8 break stop bit high", int'(txd), 1);
    wait_tc(ok);
    chk(ok, "R8 R6 tc after break", int'(tc_flag), 1);
  endtask

  task automatic t_overwrite;
    logic [8:0] d; logic s; bit g; bit ok; int lows = 0;
    write_byte(9'h011);
    cyc(5);
    write_byte(9'h022);
    write_byte(9'h033);
    recv(8, d, s, g);
    chk(g && d[7:0] == 8'h11, "R9 frame in shifter intact", int'(d), 'h11);
    recv(8, d, s, g);
    chk(g && d[7:0] == 8'h33, "R9 pending byte replaced", int'(d), 'h33);
    wait_tc(ok);
    for (int k = 0; k < 200; k++) begin cyc(1); if (txd !== 1'b1) lows++; end
    chk(lows == 0, "R9 no third frame", lows, 0);
  endtask

  task automatic t_clear;
    cyc(40);
    chk(tc_flag === 1'b1 && tde_flag === 1'b1, "R7 flags hold without strobe",
        int'({tc_flag, tde_flag}), 3);
    chk(txd === 1'b1, "R10 line high while tc set", int'(txd), 1);
    pulse_clr(1'b1);
    chk(tc_flag === 1'b0 && tde_flag === 1'b1, "R7 tc strobe clears only tc",
        int'({tc_flag, tde_flag}), 1);
    pulse_clr(1'b0);
    cyc(20);
    chk(tde_flag === 1'b0 && tc_flag === 1'b0, "R7 both stay cleared",
        int'({tc_flag, tde_flag}), 0);
  endtask

  task automatic t_disable;
    int t = 0; int lows = 0; bit ok;
    write_byte(9'h000);
    while (txd !== 1'b0 && t < 100) begin cyc(1); t++; end
    cyc(40);
    mod_off = 1'b1;
    brk_req = 1'b1; cyc(1); brk_req = 1'b0;
    cyc(1);
    for (int k = 0; k < 200; k++) begin if (txd !== 1'b1) lows++; cyc(1); end
    chk(lows == 0, "R11 line high while disabled", lows, 0);
    mod_off = 1'b0;
    lows = 0;
    for (int k = 0; k < 450; k++) begin cyc(1); if (txd !== 1'b1) lows++; end
    chk(lows == 0, "R11 break ignored while disabled", lows, 0);
    wait_tc(ok);
    chk(ok, "R11 R4 tc after re-enable", int'(tc_flag), 1);
  endtask

  task automatic t_tickgate;
    int t = 0; int moves = 0;
    write_byte(9'h05A);
    while (txd !== 1'b0 && t < 100) begin cyc(1); t++; end
    baud_tick = 1'b0;
    for (int k = 0; k < 100; k++) begin cyc(1); if (txd !== 1'b0) moves++; end
    chk(moves == 0, "R12 line frozen without ticks", moves, 0);
    baud_tick = 1'b1;
    cyc(140);
    chk(tc_flag === 1'b0, "R12 frame stretched by gap", int'(tc_flag), 0);
    cyc(35);
    chk(tc_flag === 1'b1, "R12 frame ends after resume", int'(tc_flag), 1);
  endtask

  initial begin
    rst_n = 1'b0; baud_tick = 1'b1; mode9 = 1'b0; mod_off = 1'b1;
    brk_req = 1'b0; wr_en = 1'b0; wr_data = '0; clr_tde = 1'b0; clr_tc = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(5);
    t_reset();
    t_preamble(1'b0);
    t_preamble(1'b1);
    t_frame8();
    t_frame9();
    t_break();
    t_overwrite();
    t_clear();
    t_disable();
    t_tickgate();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule